// File: doc/BRIEF.md
# Region Write-Mask Memory Guard

This block sits between a processor's byte bus and a single-port on-chip RAM. It stops one task from overwriting memory that belongs to another task or to the scheduler. The RAM window is cut into equal regions. Each region owns one bit of a privileged write-mask register. A processor write reaches the RAM only while the bit for the addressed region is set. Reads always pass.

The mask register has its own small address window and reads back as bytes. It accepts a write only while the processor's interrupt-status bit is high, so ordinary task code cannot widen its own rights. A build parameter can switch the protection off, and then every write in the RAM window goes through.

The default build has a 1 KB RAM with 16 regions of 64 bytes, giving two mask bytes. Setting `ADDR_W`=12 and `REGION_W`=5 gives a 4 KB RAM with 32 regions of 128 bytes and four mask bytes.

Top module: `region_wr_guard`

## Requirements
- R1: The region of a RAM access is taken from address bits [ADDR_W-1 : ADDR_W-REGION_W]. By default these are bits 9:6, so 0x03F is in region 0 and 0x040 is in region 1.
- R2: A write inside the RAM window to a region whose mask bit is 1 raises `ram_wr` in the same cycle.
- R3: A write inside the RAM window to a region whose mask bit is 0 keeps `ram_wr` low, and the RAM contents stay unchanged.
- R4: A write to the mask window changes the mask at the next clock edge only if `int_flag` is 1 in that cycle. With `int_flag` at 0 the mask is left unchanged, which shows both on readback and on later RAM writes.
- R5: Reset sets every mask bit to 1, so every region is writable after reset.
- R6: A read at MASK_BASE+k returns mask byte k one cycle after the read. Bit i of that byte is the bit for region 8k+i.
- R7: Reads are never gated. A read in the RAM window raises `ram_rd` in the same cycle whatever the mask holds, and the RAM data appears on `cpu_rdata` one cycle later.
- R8: With `PROTECT_EN`=0, every write in the RAM window raises `ram_wr`, whatever the mask holds.
- R9: An access outside both windows raises neither `ram_wr` nor `ram_rd` and does not change the mask, even with `int_flag` at 1.
- R10: `ram_addr` carries the low ADDR_W bits of `cpu_addr`, and `ram_wdata` carries `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | BUS_W (16) | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| int_flag | input | 1 | Processor interrupt-status bit; a mask write needs it high |
| cpu_rdata | output | 8 | Read data to the processor: a mask byte or RAM data |
| ram_addr | output | ADDR_W (10) | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_wr | output | 1 | Gated RAM write enable |
| ram_rd | output | 1 | RAM read enable |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_rd` |

## Verification
Write gating, `ram_rd`, `ram_addr` and `ram_wdata` are combinational, so the bench checks them 1 ns after it drives the inputs on the falling edge, inside the same cycle. A mask update appears only after the next rising edge, so the bench checks it through a later readback or a later gated write. Read data is due one rising edge after the read strobe. A monitor therefore pops the expected byte from the scoreboard queue 3 ns after that edge. A second instance built without protection sees the same stimulus, and its `ram_wr` is compared in the same cycle.

// File: rtl/mg_pkg.sv
package mg_pkg;

  // Region index of a byte address: the REGION_W bits just below the top of the RAM window.
  function automatic int unsigned region_of(input logic [31:0] addr,
                                            input int unsigned addr_w,
                                            input int unsigned region_w);
    logic [31:0] shifted;
    shifted = addr >> (addr_w - region_w);
    return int'(shifted & ((32'd1 << region_w) - 32'd1));
  endfunction

  // True when addr and base agree on every bit at or above position low.
  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input int unsigned low);
    return (addr >> low) == (base >> low);
  endfunction

  // Byte lane of a mask access: the low lane_w bits of the address.
  function automatic int unsigned lane_of(input logic [31:0] addr,
                                          input int unsigned lane_w);
    return int'(addr & ((32'd1 << lane_w) - 32'd1));
  endfunction

endpackage

// File: rtl/mg_decode.sv
module mg_decode #(
  parameter int unsigned BUS_W     = 16,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned REGION_W  = 4,
  parameter int unsigned RAM_BASE  = 32'h0000,
  parameter int unsigned MASK_BASE = 32'h1000,
  localparam int unsigned LANE_W   = REGION_W - 3
) (
  input  logic [BUS_W-1:0]    addr,
  output logic                ram_sel,
  output logic                mask_sel,
  output logic [REGION_W-1:0] region,
  output logic [LANE_W-1:0]   lane
);
  logic [31:0] addr_ext;

  assign addr_ext = 32'(addr);
  assign ram_sel  = mg_pkg::in_window(addr_ext, RAM_BASE, ADDR_W);
  assign mask_sel = mg_pkg::in_window(addr_ext, MASK_BASE, LANE_W);
  assign region   = REGION_W'(mg_pkg::region_of(addr_ext, ADDR_W, REGION_W));
  assign lane     = LANE_W'(mg_pkg::lane_of(addr_ext, LANE_W));
endmodule

// File: rtl/mg_mask_reg.sv
module mg_mask_reg #(
  parameter int unsigned REGION_W = 4,
  localparam int unsigned NREG    = 1 << REGION_W,
  localparam int unsigned NBYTES  = NREG / 8,
  localparam int unsigned LANE_W  = REGION_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic              int_flag,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        wdata,
  output logic              mask_we,
  output logic [NREG-1:0]   mask_q,
  output logic              rd_hit_q,
  output logic [7:0]        rd_byte_q
);
  logic [7:0] byte_view [NBYTES];

  // A mask write needs the privileged bit; every other write request is dropped.
  assign mask_we = wr_req & int_flag;

  for (genvar b = 0; b < NBYTES; b++) begin : g_view
    assign byte_view[b] = mask_q[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_we) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (lane == LANE_W'(b)) mask_q[b*8 +: 8] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hit_q  <= 1'b0;
      rd_byte_q <= 8'h00;
    end else begin
      rd_hit_q <= rd_req;
      if (rd_req) rd_byte_q <= byte_view[lane];
    end
  end
endmodule

// File: rtl/mg_wr_gate.sv
module mg_wr_gate #(
  parameter int unsigned REGION_W   = 4,
  parameter bit          PROTECT_EN = 1'b1,
  localparam int unsigned NREG      = 1 << REGION_W
) (
  input  logic                cpu_wr,
  input  logic                cpu_rd,
  input  logic                ram_sel,
  input  logic [REGION_W-1:0] region,
  input  logic [NREG-1:0]     mask_q,
  output logic                ram_wr,
  output logic                ram_rd
);
  logic region_ok;

  if (PROTECT_EN) begin : g_protect
    assign region_ok = mask_q[region];
  end else begin : g_open
    assign region_ok = 1'b1;
  end

  assign ram_wr = cpu_wr & ram_sel & region_ok;
  assign ram_rd = cpu_rd & ram_sel;
endmodule

// File: rtl/region_wr_guard.sv
module region_wr_guard #(
  parameter int unsigned BUS_W      = 16,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned REGION_W   = 4,
  parameter int unsigned RAM_BASE   = 32'h0000,
  parameter int unsigned MASK_BASE  = 32'h1000,
  parameter bit          PROTECT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic              int_flag,
  output logic [7:0]        cpu_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ram_wr,
  output logic              ram_rd,
  input  logic [7:0]        ram_rdata
);
  localparam int unsigned NREG   = 1 << REGION_W;
  localparam int unsigned LANE_W = REGION_W - 3;

  logic                ram_sel;
  logic                mask_sel;
  logic [REGION_W-1:0] region;
  logic [LANE_W-1:0]   lane;
  logic                mask_we;
  logic [NREG-1:0]     mask_q;
  logic                rd_hit_q;
  logic [7:0]          rd_byte_q;

  mg_decode #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .REGION_W(REGION_W),
    .RAM_BASE(RAM_BASE), .MASK_BASE(MASK_BASE)
  ) decode_i (
    .addr(cpu_addr), .ram_sel(ram_sel), .mask_sel(mask_sel),
    .region(region), .lane(lane)
  );

  mg_mask_reg #(.REGION_W(REGION_W)) mask_i (
    .clk(clk), .rst_n(rst_n),
    .wr_req(mask_sel & cpu_wr), .rd_req(mask_sel & cpu_rd),
    .int_flag(int_flag), .lane(lane), .wdata(cpu_wdata),
    .mask_we(mask_we), .mask_q(mask_q),
    .rd_hit_q(rd_hit_q), .rd_byte_q(rd_byte_q)
  );

  mg_wr_gate #(.REGION_W(REGION_W), .PROTECT_EN(PROTECT_EN)) gate_i (
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ram_sel(ram_sel),
    .region(region), .mask_q(mask_q),
    .ram_wr(ram_wr), .ram_rd(ram_rd)
  );

  assign ram_addr  = cpu_addr[ADDR_W-1:0];
  assign ram_wdata = cpu_wdata;
  assign cpu_rdata = rd_hit_q ? rd_byte_q : ram_rdata;
endmodule

// File: rtl/mg_checker.sv
module mg_checker #(
  parameter int unsigned BUS_W      = 16,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned REGION_W   = 4,
  parameter bit          PROTECT_EN = 1'b1,
  localparam int unsigned NREG      = 1 << REGION_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] cpu_addr,
  input logic             cpu_wr,
  input logic             cpu_rd,
  input logic             int_flag,
  input logic             ram_sel,
  input logic             mask_we,
  input logic [NREG-1:0]  mask_q,
  input logic             ram_wr,
  input logic             ram_rd
);
  logic [REGION_W-1:0] chk_region;
  assign chk_region = cpu_addr[ADDR_W-1 -: REGION_W];

  if (PROTECT_EN) begin : g_prot_chk
    assert_wr_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && ram_sel && mask_q[chk_region]) |-> ram_wr);
    assert_wr_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && ram_sel && !mask_q[chk_region]) |-> !ram_wr);
  end else begin : g_open_chk
    assert_wr_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && ram_sel) |-> ram_wr);
  end

  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && int_flag) |=> $stable(mask_q));

  assert_reset_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&mask_q));

  assert_rd_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && ram_sel) |-> ram_rd);

  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_wr, mask_we}));
endmodule

bind region_wr_guard mg_checker #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .REGION_W(REGION_W), .PROTECT_EN(PROTECT_EN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .cpu_rd(cpu_rd), .int_flag(int_flag), .ram_sel(ram_sel),
  .mask_we(mask_we), .mask_q(mask_q), .ram_wr(ram_wr), .ram_rd(ram_rd)
);

// File: tb/region_wr_guard_tb_top.sv
module region_wr_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0, int_flag = 1'b0;
  logic [7:0]  cpu_rdata, ram_wdata, ram_rdata = '0;
  logic [9:0]  ram_addr;
  logic        ram_wr, ram_rd;

  logic [7:0]  np_rdata, np_wdata;
  logic [9:0]  np_addr;
  logic        np_wr, np_rd;
  logic [7:0]  np_ram_rdata = '0;

  int checks = 0, errors = 0;
  logic mon_rd = 1'b0;
  logic done = 1'b0;
  logic [7:0] mem [1024];
  logic [7:0] exp_mem [1024];
  logic [15:0] exp_mask = 16'hFFFF;
  logic [7:0] exp_q [$];
  string req_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  region_wr_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .int_flag(int_flag), .cpu_rdata(cpu_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_wr(ram_wr), .ram_rd(ram_rd),
    .ram_rdata(ram_rdata)
  );

  region_wr_guard #(.PROTECT_EN(1'b0)) dut_np (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .int_flag(int_flag), .cpu_rdata(np_rdata),
    .ram_addr(np_addr), .ram_wdata(np_wdata), .ram_wr(np_wr), .ram_rd(np_rd),
    .ram_rdata(np_ram_rdata)
  );

  // RAM model with one cycle of read latency.
  always @(posedge clk) begin
    if (ram_wr) mem[ram_addr] <= ram_wdata;
    if (ram_rd) ram_rdata <= mem[ram_addr];
  end

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic in_ram(input logic [15:0] a);
    return a < 16'd1024;
  endfunction
  function automatic logic in_mask(input logic [15:0] a);
    return a == 16'h1000 || a == 16'h1001;
  endfunction

  task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                          input logic iflag, input string req);
    logic pass;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0; int_flag = iflag;
    #1;
    pass = in_ram(a) && exp_mask[a / 64];
    check(ram_wr == pass, req, "ram_wr", int'(ram_wr), int'(pass));
    check(np_wr == in_ram(a), "R8", "open ram_wr", int'(np_wr), int'(in_ram(a)));
    if (pass) begin
      check(ram_addr == a[9:0] && ram_wdata == d, "R10", "addr/data",
            int'({ram_addr, ram_wdata}), int'({a[9:0], d}));
      exp_mem[a] = d;
    end
    if (in_mask(a) && iflag) begin
      if (a[0]) exp_mask[15:8] = d; else exp_mask[7:0] = d;
    end
    @(posedge clk);
    #1 cpu_wr = 1'b0; int_flag = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    e = in_ram(a) ? exp_mem[a] : (a[0] ? exp_mask[15:8] : exp_mask[7:0]);
    exp_q.push_back(e);
    req_q.push_back(req);
    mon_rd = 1'b1;
    #1;
    check(ram_rd == in_ram(a), "R7", "ram_rd", int'(ram_rd), int'(in_ram(a)));
    @(posedge clk);
    #1 cpu_rd = 1'b0; mon_rd = 1'b0;
  endtask

  // Monitor: read data is due one rising edge after the read strobe.
  always @(posedge clk) begin
    if (mon_rd) begin
      logic [7:0] e;
      string r;
      #3;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(cpu_rdata == e, r, "cpu_rdata", int'(cpu_rdata), int'(e));
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R5 and R6: reset mask reads back as all ones
    do_read(16'h1000, "R5");
    do_read(16'h1001, "R5");

    // R2: open writes across several regions
    do_write(16'h0000, 8'h10, 1'b0, "R2");
    do_write(16'h0045, 8'h11, 1'b0, "R2");
    do_write(16'h03FF, 8'h12, 1'b0, "R2");
    do_write(16'h0200, 8'h13, 1'b0, "R2");

    // R4: unprivileged mask write is ignored
    do_write(16'h1000, 8'h00, 1'b0, "R4");
    do_read(16'h1000, "R4");
    do_write(16'h00C3, 8'h21, 1'b0, "R4");

    // R4 and R6: privileged mask writes, then byte readback
    do_write(16'h1000, 8'hA5, 1'b1, "R4");
    do_write(16'h1001, 8'h0F, 1'b1, "R4");
    do_read(16'h1000, "R6");
    do_read(16'h1001, "R6");

    // R9: address outside both windows
    do_write(16'h1002, 8'h00, 1'b1, "R9");
    do_write(16'h2000, 8'h5A, 1'b1, "R9");
    do_read(16'h1000, "R9");
    do_read(16'h1001, "R9");

    // R1 boundary and R3 blocking
    do_write(16'h003F, 8'h31, 1'b0, "R1");
    do_write(16'h0040, 8'h32, 1'b0, "R1");
    do_write(16'h0045, 8'h99, 1'b0, "R3");
    do_write(16'h03FF, 8'h77, 1'b0, "R3");
    do_write(16'h0200, 8'h44, 1'b0, "R2");
    do_write(16'h02FF, 8'h45, 1'b0, "R2");
    do_write(16'h0300, 8'h46, 1'b0, "R3");

    // R7: reads from protected regions still return stored data
    do_read(16'h0045, "R7");
    do_read(16'h03FF, "R7");
    do_read(16'h0040, "R3");
    do_read(16'h003F, "R7");
    do_read(16'h0200, "R7");
    do_read(16'h0300, "R3");

    // R4: reopen region 1 and write through
    do_write(16'h1000, 8'hFF, 1'b1, "R4");
    do_write(16'h0045, 8'h55, 1'b0, "R4");
    do_read(16'h0045, "R4");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule